// File: doc/BRIEF.md
# Reset Control Register Sequencer

This block holds one byte-wide I/O register that software writes to ask for a reset. The sequencer watches that register and three external reset requests, and turns them into timed, active-low reset pulses. There are three kinds of reset:

- A soft reset pulses the processor INIT line for a fixed number of PCI clocks.
- A hard reset holds PCI reset for about a millisecond.
- A full reset also drops both sleep-state lines (S3 and S4) for about four seconds, which power-cycles the platform.

Long durations are measured with a slow strobe, `tick_i`, which pulses once every 0.5 ms. Short durations are counted in PCI clocks.

Software writes bit 1 to choose soft (0) or hard (1), and bit 3 to turn a hard reset into a full one. The reset itself starts only when the same write also moves bit 2 from 0 to 1. Bit 2 then reads 1 until the sequence finishes. The three external sources are the reset button, loss of core power-good and watchdog expiry. Each one starts a full reset when bit 3 is set and a hard reset when it is clear.

Top module: `reset_ctl`

## Requirements
- R1: After reset the register reads 00h. Bits 7:4 and bit 0 always read 0. Bit 3 (full enable) and bit 1 (hard select) read back the last written value.
- R2: A sequence starts only when a write carries bit 2 = 1 while no sequence is running. Bit 2 reads 1 for the whole sequence and reads 0 again once it ends, so a later write can start another sequence.
- R3: If the starting write has bit 1 = 0, `init_no` is low for exactly SOFT_CYCLES (16) clocks. During that time `pci_rst_no`, `slp_s3_no` and `slp_s4_no` stay high.
- R4: If the starting write has bit 1 = 1 and bit 3 = 0, `pci_rst_no` goes low. It returns high on the HARD_TICKS-th (2nd) tick after the start, which is 1 ms within one tick. The sleep lines stay high.
- R5: If the starting write has bit 3 = 1 and bit 1 = 1, `pci_rst_no`, `slp_s3_no` and `slp_s4_no` all go low together. They return high on the FULL_TICKS-th (8000th) tick, which is 4 s.
- R6: The following external events start a sequence: a rising edge of `rst_btn_i`, a rising edge of `wdt_rst_i`, or a falling edge of `core_pwrok_i`. The sequence is full (R5 timing) when the stored bit 3 is 1, and hard (R4 timing) when it is 0.
- R7: Any trigger, whether a software write or an external event, that arrives while a sequence is running is ignored. No second pulse follows.
- R8: When a hard or full sequence ends, the register returns to 00h. When a soft sequence ends, bits 3 and 1 keep their values.
- R9: External inputs pass through a two-flop synchronizer and an edge detector. A request held high for many clocks starts exactly one sequence, and the return of power-good starts none.
- R10: `init_no` and `pci_rst_no` are never low at the same time. `slp_s3_no` always equals `slp_s4_no`, and the sleep lines are low only while `pci_rst_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock strobe every 0.5 ms |
| io_wr_i | input | 1 | Register write strobe |
| io_wdata_i | input | 8 | Register write data |
| io_rdata_o | output | 8 | Register read data |
| rst_btn_i | input | 1 | Reset button pressed (asynchronous, high = pressed) |
| core_pwrok_i | input | 1 | Core power good (asynchronous, low = lost) |
| wdt_rst_i | input | 1 | Watchdog reset request (asynchronous) |
| init_no | output | 1 | Processor INIT, active low |
| pci_rst_no | output | 1 | PCI reset, active low |
| slp_s3_no | output | 1 | Sleep S3 control, active low |
| slp_s4_no | output | 1 | Sleep S4 control, active low |

## Verification
The bench writes 1 to bit 2 while a soft or full sequence is already running.
- A design that detects the trigger by level instead of by edge would stretch the pulse or add a second one.
- A design that allows a retrigger would add a second pulse.

The reset button is held high for dozens of clocks and power-good is restored after a loss. A missing edge detector would either start repeated sequences or start a sequence on power-good recovery.

The bench checks the register value at the end of each kind of sequence. A design that clears on every sequence would lose the soft-reset settings, and one that never clears would leave bit 3 armed after a full cycle.

The bench measures every pulse width against the tick window, and expects no sleep pulse during a hard reset. This catches timers that are off by one tick and designs that drop the sleep lines without the full enable.

// File: rtl/reset_ctl_pkg.sv
package reset_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SOFT,
    ST_HARD,
    ST_FULL
  } seq_state_e;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned BIT_FULL = 3;
  localparam int unsigned BIT_TRIG = 2;
  localparam int unsigned BIT_HARD = 1;
  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/reset_ctl_sync.sv
module reset_ctl_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic evt_o
);
  logic [2:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[1:0], async_i};
  end

  // ff_q[1] is synchronized, ff_q[2] is its previous value
  assign evt_o = ff_q[1] & ~ff_q[2];
endmodule

// File: rtl/reset_ctl_fsm.sv
module reset_ctl_fsm
  import reset_ctl_pkg::*;
#(
  parameter int unsigned SOFT_CYCLES = 16,
  parameter int unsigned HARD_TICKS  = 2,
  parameter int unsigned FULL_TICKS  = 8000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_soft_i,
  input  logic       start_hard_i,
  input  logic       start_full_i,
  output seq_state_e state_o,
  output logic       done_soft_o,
  output logic       done_clr_o
);
  localparam int unsigned MAX_TICKS = (FULL_TICKS > HARD_TICKS) ? FULL_TICKS : HARD_TICKS;
  localparam int unsigned CYC_W = (SOFT_CYCLES > 1) ? $clog2(SOFT_CYCLES) : 1;
  localparam int unsigned TCK_W = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(SOFT_CYCLES - 1);
  localparam logic [TCK_W-1:0] HARD_LAST = TCK_W'(HARD_TICKS - 1);
  localparam logic [TCK_W-1:0] FULL_LAST = TCK_W'(FULL_TICKS - 1);

  seq_state_e       state_q;
  logic [CYC_W-1:0] cyc_q;
  logic [TCK_W-1:0] tck_q;
  logic             soft_end, hard_end, full_end;

  assign soft_end = (state_q == ST_SOFT) && (cyc_q == CYC_LAST);
  assign hard_end = (state_q == ST_HARD) && tick_i && (tck_q == HARD_LAST);
  assign full_end = (state_q == ST_FULL) && tick_i && (tck_q == FULL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      tck_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cyc_q <= '0;
          tck_q <= '0;
          if      (start_full_i) state_q <= ST_FULL;
          else if (start_hard_i) state_q <= ST_HARD;
          else if (start_soft_i) state_q <= ST_SOFT;
        end
        ST_SOFT: begin
          if (soft_end) state_q <= ST_IDLE;
          else          cyc_q   <= cyc_q + 1'b1;
        end
        ST_HARD, ST_FULL: begin
          if (hard_end || full_end) state_q <= ST_IDLE;
          else if (tick_i)          tck_q   <= tck_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign done_soft_o = soft_end;
  assign done_clr_o  = hard_end | full_end;
endmodule

// File: rtl/reset_ctl.sv
module reset_ctl
  import reset_ctl_pkg::*;
#(
  parameter int unsigned SOFT_CYCLES = 16,
  parameter int unsigned HARD_TICKS  = 2,
  parameter int unsigned FULL_TICKS  = 8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             io_wr_i,
  input  logic [REG_W-1:0] io_wdata_i,
  output logic [REG_W-1:0] io_rdata_o,
  input  logic             rst_btn_i,
  input  logic             core_pwrok_i,
  input  logic             wdt_rst_i,
  output logic             init_no,
  output logic             pci_rst_no,
  output logic             slp_s3_no,
  output logic             slp_s4_no
);
  seq_state_e         state;
  logic               done_soft, done_clr;
  logic               full_q, hard_q, busy;
  logic [NUM_SRC-1:0] src_raw, src_evt;
  logic               sw_trig, ext_trig;
  logic               start_soft, start_hard, start_full;

  // power-good loss is seen as a rising request
  assign src_raw = {wdt_rst_i, ~core_pwrok_i, rst_btn_i};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    reset_ctl_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(src_raw[i]),
      .evt_o  (src_evt[i])
    );
  end

  assign busy     = (state != ST_IDLE);
  assign sw_trig  = io_wr_i && io_wdata_i[BIT_TRIG] && !busy;
  assign ext_trig = (|src_evt) && !busy && !sw_trig;

  assign start_soft = sw_trig && !io_wdata_i[BIT_HARD];
  assign start_hard = (sw_trig && io_wdata_i[BIT_HARD] && !io_wdata_i[BIT_FULL])
                    || (ext_trig && !full_q);
  assign start_full = (sw_trig && io_wdata_i[BIT_HARD] && io_wdata_i[BIT_FULL])
                    || (ext_trig && full_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hard_q <= 1'b0;
    end else if (done_clr) begin
      full_q <= 1'b0;
      hard_q <= 1'b0;
    end else if (io_wr_i) begin
      full_q <= io_wdata_i[BIT_FULL];
      hard_q <= io_wdata_i[BIT_HARD];
    end
  end

  reset_ctl_fsm #(
    .SOFT_CYCLES(SOFT_CYCLES),
    .HARD_TICKS (HARD_TICKS),
    .FULL_TICKS (FULL_TICKS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .start_soft_i(start_soft),
    .start_hard_i(start_hard),
    .start_full_i(start_full),
    .state_o     (state),
    .done_soft_o (done_soft),
    .done_clr_o  (done_clr)
  );

  always_comb begin
    io_rdata_o           = '0;
    io_rdata_o[BIT_FULL] = full_q;
    io_rdata_o[BIT_TRIG] = busy;
    io_rdata_o[BIT_HARD] = hard_q;
  end

  assign init_no    = (state != ST_SOFT);
  assign pci_rst_no = !((state == ST_HARD) || (state == ST_FULL));
  assign slp_s3_no  = (state != ST_FULL);
  assign slp_s4_no  = (state != ST_FULL);
endmodule

// File: rtl/reset_ctl_chk.sv
module reset_ctl_chk #(
  parameter int unsigned SOFT_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] io_rdata_o,
  input logic       init_no,
  input logic       pci_rst_no,
  input logic       slp_s3_no,
  input logic       slp_s4_no
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           low_cnt <= '0;
    else if (init_no)      low_cnt <= '0;
    else if (~&low_cnt)    low_cnt <= low_cnt + 1'b1;
  end

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rdata_o[7:4] == 4'h0 && !io_rdata_o[0]);

  a_r2_busy_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_no || !pci_rst_no) |-> io_rdata_o[2]);

  a_r3_soft_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_no) |-> low_cnt == 16'(SOFT_CYCLES));

  a_r4_hard_no_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pci_rst_no && slp_s3_no) |=> slp_s3_no);

  a_r8_clear_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_rst_no) |-> io_rdata_o == 8'h00);

  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_no || pci_rst_no);

  a_r10_sleep_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slp_s3_no == slp_s4_no);

  a_r10_sleep_in_pci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slp_s3_no |-> !pci_rst_no);
endmodule

bind reset_ctl reset_ctl_chk #(.SOFT_CYCLES(SOFT_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .io_rdata_o(io_rdata_o),
  .init_no   (init_no),
  .pci_rst_no(pci_rst_no),
  .slp_s3_no (slp_s3_no),
  .slp_s4_no (slp_s4_no)
);

// File: tb/reset_ctl_bench.sv
module reset_ctl_bench;
  localparam int unsigned SOFT_N = 16;
  localparam int unsigned HARD_N = 2;
  localparam int unsigned FULL_N = 8000;
  localparam int unsigned TICK_P = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       io_wr_i = 1'b0;
  logic [7:0] io_wdata_i = '0;
  logic [7:0] io_rdata_o;
  logic       rst_btn_i = 1'b0;
  logic       core_pwrok_i = 1'b1;
  logic       wdt_rst_i = 1'b0;
  logic       init_no, pci_rst_no, slp_s3_no, slp_s4_no;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    int    lo;
    int    hi;
    string req;
  } exp_t;

  exp_t sbq[3][$];  // 0 init, 1 pci, 2 sleep

  always #2.5 clk = ~clk;

  reset_ctl u_reset_ctl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .io_wr_i     (io_wr_i),
    .io_wdata_i  (io_wdata_i),
    .io_rdata_o  (io_rdata_o),
    .rst_btn_i   (rst_btn_i),
    .core_pwrok_i(core_pwrok_i),
    .wdt_rst_i   (wdt_rst_i),
    .init_no     (init_no),
    .pci_rst_no  (pci_rst_no),
    .slp_s3_no   (slp_s3_no),
    .slp_s4_no   (slp_s4_no)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pulse(input int idx, input int lo, input int hi, input string req);
    exp_t e;
    e.lo = lo; e.hi = hi; e.req = req;
    sbq[idx].push_back(e);
  endtask

  task automatic score(input int idx, input int w);
    exp_t e;
    if (sbq[idx].size() == 0) begin
      check(1'b0, $sformatf("R7 unexpected pulse on output %0d", idx), w, 0);
    end else begin
      e = sbq[idx].pop_front();
      check(w >= e.lo && w <= e.hi, $sformatf("%s width on output %0d", e.req, idx), w, e.lo);
    end
  endtask

  // tick: one clock high every TICK_P clocks
  initial forever begin
    @(negedge clk);
    tick_i = !tick_i;
  end

  // monitor: measures every low pulse and scores it
  initial begin
    int w[3];
    logic [2:0] lv;
    w = '{0, 0, 0};
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        lv = {slp_s3_no, pci_rst_no, init_no};
        for (int i = 0; i < 3; i++) begin
          if (!lv[i]) w[i]++;
          else if (w[i] > 0) begin
            score(i, w[i]);
            w[i] = 0;
          end
        end
        if (slp_s4_no != slp_s3_no) check(1'b0, "R10 s4 mismatch", slp_s4_no, slp_s3_no);
      end
    end
  end

  task automatic io_write(input logic [7:0] d);
    @(negedge clk);
    io_wr_i = 1'b1;
    io_wdata_i = d;
    @(negedge clk);
    io_wr_i = 1'b0;
  endtask

  task automatic chk_reg(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(io_rdata_o == exp, req, io_rdata_o, exp);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (io_rdata_o[2]);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(2.5ns * 2 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk_reg(8'h00, "R1 reset value");
    check(init_no && pci_rst_no && slp_s3_no, "R1 outputs idle", {init_no, pci_rst_no, slp_s3_no}, 7);

    // R1 reserved bits, no trigger without bit 2
    io_write(8'hFB);
    chk_reg(8'h0A, "R1 reserved read zero");
    repeat (5) @(negedge clk);
    check(init_no && pci_rst_no, "R2 no start without bit 2", {init_no, pci_rst_no}, 3);
    io_write(8'h00);

    // R3 soft reset, R7 retrigger ignored mid-pulse
    expect_pulse(0, SOFT_N, SOFT_N, "R3");
    io_write(8'h04);
    check(io_rdata_o == 8'h04, "R2 busy bit set", io_rdata_o, 8'h04);
    repeat (3) @(negedge clk);
    io_write(8'h04);
    wait_idle();
    chk_reg(8'h00, "R2 busy bit clears");

    // R8 soft keeps bits 3 and 1 selections (bit 3 with soft)
    expect_pulse(0, SOFT_N, SOFT_N, "R3");
    io_write(8'h0C);
    wait_idle();
    chk_reg(8'h08, "R8 soft keeps bit 3");
    io_write(8'h00);

    // R4 hard reset, twice to show rearm (R2)
    for (int k = 0; k < 2; k++) begin
      expect_pulse(1, (HARD_N-1)*TICK_P+1, HARD_N*TICK_P, "R4");
      io_write(8'h06);
      wait_idle();
      chk_reg(8'h00, "R8 hard clears register");
    end

    // R6/R9 button with bit 3 clear -> one hard reset despite long hold
    io_write(8'h02);
    expect_pulse(1, (HARD_N-1)*TICK_P+1, HARD_N*TICK_P, "R6");
    rst_btn_i = 1'b1;
    repeat (60) @(negedge clk);
    rst_btn_i = 1'b0;
    wait_idle();
    chk_reg(8'h00, "R9 one sequence per hold");

    // R5 full reset by software, R7 retrigger ignored
    expect_pulse(1, (FULL_N-1)*TICK_P+1, FULL_N*TICK_P, "R5");
    expect_pulse(2, (FULL_N-1)*TICK_P+1, FULL_N*TICK_P, "R5");
    io_write(8'h0E);
    repeat (100) @(negedge clk);
    check(!slp_s3_no && !slp_s4_no && !pci_rst_no, "R5 all low", {slp_s3_no, slp_s4_no, pci_rst_no}, 0);
    io_write(8'h0E);
    wait_idle();
    chk_reg(8'h00, "R8 full clears register");

    // R6 watchdog with bit 3 set -> full
    io_write(8'h08);
    expect_pulse(1, (FULL_N-1)*TICK_P+1, FULL_N*TICK_P, "R6");
    expect_pulse(2, (FULL_N-1)*TICK_P+1, FULL_N*TICK_P, "R6");
    wdt_rst_i = 1'b1;
    repeat (10) @(negedge clk);
    wdt_rst_i = 1'b0;
    wait_idle();

    // R6/R9 power-good loss with bit 3 set -> full, recovery adds nothing
    io_write(8'h08);
    expect_pulse(1, (FULL_N-1)*TICK_P+1, FULL_N*TICK_P, "R6");
    expect_pulse(2, (FULL_N-1)*TICK_P+1, FULL_N*TICK_P, "R6");
    core_pwrok_i = 1'b0;
    repeat (20) @(negedge clk);
    core_pwrok_i = 1'b1;
    wait_idle();
    repeat (20) @(negedge clk);
    check(pci_rst_no && io_rdata_o == 8'h00, "R9 no start on power-good return", io_rdata_o, 0);

    for (int i = 0; i < 3; i++)
      check(sbq[i].size() == 0, $sformatf("R7 missing pulse on output %0d", i), sbq[i].size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule